// File: doc/BRIEF.md
# Static-Memory Bus Turnaround Gap Controller

This block stands between an access source and an asynchronous static-memory bus that is shared by several chip-select banks. Requests arrive on a valid/ready handshake. Each one names a bank and a direction, and gives a lane selection (full 16-bit word, low byte or high byte) and write data. Before the block lets a request onto the bus, it makes sure enough idle bus cycles have passed since the previous access. This keeps the driver that is leaving the bus from fighting the one that is taking it over.

The required gap depends only on the previous access and the new one. Two accesses in the same direction to the same bank need the previous bank's idle count. A change of direction, or a move to another bank, needs that bank's idle count plus its turnaround count. The block counts the cycles that have passed since the last accepted access. It holds ready low until that count reaches the gap the waiting request needs. If the bus has already been quiet for long enough, the request is accepted at once.

An accepted access is issued on the next cycle. At the same time the block drives the two active-low byte-enable lines and their output enable. Reads leave the byte enables undriven. Writes drive them according to the lane selection.

Top module: `mgap_ctrl`

## Requirements
- R1: Each of the four banks has a 4-bit idle count and a 4-bit turnaround count. Bank i's counts sit at bits [4i+3:4i] of `cfg_idle` and `cfg_turn`. The gap before a request is always computed from the counts of the bank used by the previously accepted access.
- R2: After an access, a request to the same bank in the same direction needs an idle gap equal to that bank's idle count.
- R3: After an access, a request to the same bank in the other direction needs an idle gap equal to the idle count plus the turnaround count.
- R4: After an access, a request to any other bank, in either direction, needs an idle gap equal to the idle count plus the turnaround count of the previous bank.
- R5: The first request after reset is accepted with no gap, whatever the configuration.
- R6: A gap of G cycles means that if the previous access was accepted at edge k, `req_ready` is low before edge k+G+1 and high from then on. A request waiting during the gap is held until it is accepted. After G or more quiet cycles, a request is accepted in its first cycle.
- R7: A request accepted at edge k shows `iss_valid` high for exactly the cycle after edge k. In that cycle its bank, direction and (for writes) data appear on `iss_bank`, `iss_write` and `iss_wdata`. `iss_valid` is low in every other cycle.
- R8: `be_oe` stays low for the whole of an issued read, and in every cycle in which no write is being issued.
- R9: A write with `req_lane` = 00 or 11 (full word) is issued with `be_oe` high and `be_n` = 00.
- R10: A write with `req_lane` = 10 (upper byte) gives `be_n` = 01, with the upper enable `be_n[1]` low. A write with `req_lane` = 01 (lower byte) gives `be_n` = 10. In both cases `be_oe` is high.
- R11: While reset is held, `iss_valid` and `be_oe` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_lane | input | 2 | 00/11 full word, 01 low byte, 10 high byte |
| req_wdata | input | 16 | Write data |
| cfg_idle | input | 16 | Per-bank idle counts, 4 bits each |
| cfg_turn | input | 16 | Per-bank turnaround counts, 4 bits each |
| iss_valid | output | 1 | Access issued this cycle |
| iss_write | output | 1 | Direction of issued access |
| iss_bank | output | 2 | Bank of issued access |
| iss_wdata | output | 16 | Data of issued write |
| be_n | output | 2 | Active-low byte enables, bit 1 upper |
| be_oe | output | 1 | Byte-enable output enable |

## Verification
`req_ready` is combinational from the held history and the presented request. The bench therefore compares it in the same cycle, one time step after it drives a request at the falling edge, against a model of the elapsed quiet cycles. The issue outputs and byte enables come out one register after the accepting edge. The bench records what it expects at acceptance and compares at the following falling edge. Directed sequences cover the first access, each history case with maximum counts, and a long quiet period. After those, random traffic under changing per-bank counts exercises every gap case.

// File: rtl/mgap_pkg.sv
package mgap_pkg;
    localparam int NBANK  = 4;
    localparam int CNT_W  = 4;
    localparam int DATA_W = 16;
    localparam int BANK_W = $clog2(NBANK);
    localparam int GAP_W  = CNT_W + 1;
    localparam int CFG_W  = NBANK * CNT_W;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [GAP_W-1:0]  gap_t;
    typedef logic [CFG_W-1:0]  cfg_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam gap_t GAP_MAX = '1;

    localparam logic [1:0] LANE_LO = 2'b01;
    localparam logic [1:0] LANE_HI = 2'b10;

    typedef struct packed {
        logic  valid;
        logic  wr;
        bank_t bank;
    } hist_t;

    function automatic gap_t gap_need(hist_t h, logic wr, bank_t bank,
                                      cfg_t idle, cfg_t turn);
        logic [CNT_W-1:0] ic;
        logic [CNT_W-1:0] tc;
        gap_t g;
        ic = idle[h.bank*CNT_W +: CNT_W];
        tc = turn[h.bank*CNT_W +: CNT_W];
        g  = GAP_W'(ic);
        if (h.bank != bank || h.wr != wr)
            g = g + GAP_W'(tc);
        if (!h.valid)
            g = '0;
        return g;
    endfunction

    function automatic logic [1:0] lane_be_n(logic [1:0] lane);
        case (lane)
            LANE_LO: return 2'b10;
            LANE_HI: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/mgap_timer.sv
module mgap_timer
    import mgap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  acc_write,
    input  bank_t acc_bank,
    output hist_t hist,
    output gap_t  since
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            since <= GAP_MAX;
        end else if (accept) begin
            hist.valid <= 1'b1;
            hist.wr    <= acc_write;
            hist.bank  <= acc_bank;
            since      <= '0;
        end else if (since != GAP_MAX) begin
            since <= since + 1'b1;
        end
    end

    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        accept |=> (since == '0 && hist.valid));

    assert_count_R6: assert property (@(posedge clk) disable iff (rst)
        (!accept && since != GAP_MAX) |=> since == gap_t'($past(since) + 1'b1));

    assert_hist_R1: assert property (@(posedge clk) disable iff (rst)
        accept |=> (hist.bank == $past(acc_bank) && hist.wr == $past(acc_write)));
endmodule

// File: rtl/mgap_calc.sv
module mgap_calc
    import mgap_pkg::*;
(
    input  hist_t hist,
    input  gap_t  since,
    input  logic  req_write,
    input  bank_t req_bank,
    input  cfg_t  cfg_idle,
    input  cfg_t  cfg_turn,
    output logic  gap_ok
);
    gap_t need;

    always_comb begin
        need   = gap_need(hist, req_write, req_bank, cfg_idle, cfg_turn);
        gap_ok = (since >= need);
    end
endmodule

// File: rtl/mgap_issue.sv
module mgap_issue
    import mgap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       acc_write,
    input  bank_t      acc_bank,
    input  logic [1:0] acc_lane,
    input  data_t      acc_wdata,
    output logic       iss_valid,
    output logic       iss_write,
    output bank_t      iss_bank,
    output data_t      iss_wdata,
    output logic [1:0] be_n,
    output logic       be_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            iss_valid <= 1'b0;
            iss_write <= 1'b0;
            iss_bank  <= '0;
            iss_wdata <= '0;
            be_n      <= 2'b11;
            be_oe     <= 1'b0;
        end else if (accept) begin
            iss_valid <= 1'b1;
            iss_write <= acc_write;
            iss_bank  <= acc_bank;
            iss_wdata <= acc_wdata;
            be_oe     <= acc_write;
            be_n      <= acc_write ? lane_be_n(acc_lane) : 2'b11;
        end else begin
            iss_valid <= 1'b0;
            be_oe     <= 1'b0;
            be_n      <= 2'b11;
        end
    end

    assert_read_hiz_R8: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_write) |-> !be_oe);

    assert_drive_only_write_R9: assert property (@(posedge clk) disable iff (rst)
        be_oe |-> (iss_valid && iss_write));

    assert_lane_active_R10: assert property (@(posedge clk) disable iff (rst)
        be_oe |-> ($countones(be_n) <= 1));
endmodule

// File: rtl/mgap_ctrl.sv
module mgap_ctrl
    import mgap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [1:0]        req_lane,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CFG_W-1:0]  cfg_idle,
    input  logic [CFG_W-1:0]  cfg_turn,
    output logic              iss_valid,
    output logic              iss_write,
    output logic [BANK_W-1:0] iss_bank,
    output logic [DATA_W-1:0] iss_wdata,
    output logic [1:0]        be_n,
    output logic              be_oe
);
    hist_t hist;
    gap_t  since;
    logic  gap_ok;
    logic  accept;

    assign req_ready = gap_ok;
    assign accept    = req_valid && gap_ok;

    mgap_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .acc_write (req_write),
        .acc_bank  (req_bank),
        .hist      (hist),
        .since     (since)
    );

    mgap_calc u_calc (
        .hist      (hist),
        .since     (since),
        .req_write (req_write),
        .req_bank  (req_bank),
        .cfg_idle  (cfg_idle),
        .cfg_turn  (cfg_turn),
        .gap_ok    (gap_ok)
    );

    mgap_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .acc_write (req_write),
        .acc_bank  (req_bank),
        .acc_lane  (req_lane),
        .acc_wdata (req_wdata),
        .iss_valid (iss_valid),
        .iss_write (iss_write),
        .iss_bank  (iss_bank),
        .iss_wdata (iss_wdata),
        .be_n      (be_n),
        .be_oe     (be_oe)
    );

    assert_issue_follows_R7: assert property (@(posedge clk) disable iff (rst)
        accept |=> iss_valid);

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !iss_valid);
endmodule

// File: tb/mgap_ctrl_tb_top.sv
module mgap_ctrl_tb_top;
    import mgap_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        req_valid, req_ready, req_write;
    bank_t       req_bank;
    logic [1:0]  req_lane;
    data_t       req_wdata;
    cfg_t        cfg_idle, cfg_turn;
    logic        iss_valid, iss_write;
    bank_t       iss_bank;
    data_t       iss_wdata;
    logic [1:0]  be_n;
    logic        be_oe;

    mgap_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_lane(req_lane),
        .req_wdata(req_wdata), .cfg_idle(cfg_idle), .cfg_turn(cfg_turn),
        .iss_valid(iss_valid), .iss_write(iss_write), .iss_bank(iss_bank),
        .iss_wdata(iss_wdata), .be_n(be_n), .be_oe(be_oe)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    int idle_a[NBANK];
    int turn_a[NBANK];

    bit hv; int hb; bit hw; int el;
    bit e_v; bit e_w; int e_b; logic [1:0] e_lane; data_t e_d;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int need_f(int b, bit w);
        int n;
        if (!hv) return 0;
        n = idle_a[hb];
        if (hb != b || hw != w) n += turn_a[hb];
        return n;
    endfunction

    function automatic string tag_f(int b, bit w);
        if (!hv) return "R5";
        if (el < need_f(b, w)) return "R6";
        if (hb != b) return "R4 (R1)";
        if (hw != w) return "R3";
        return "R2";
    endfunction

    task automatic apply_cfg();
        for (int i = 0; i < NBANK; i++) begin
            cfg_idle[i*CNT_W +: CNT_W] = CNT_W'(idle_a[i]);
            cfg_turn[i*CNT_W +: CNT_W] = CNT_W'(turn_a[i]);
        end
    endtask

    task automatic check_iss();
        chk(iss_valid == e_v, "R7", "iss_valid", iss_valid, e_v);
        if (e_v) begin
            chk(int'(iss_bank) == e_b, "R7", "iss_bank", iss_bank, e_b);
            chk(iss_write == e_w, "R7", "iss_write", iss_write, e_w);
            if (!e_w) begin
                chk(be_oe == 1'b0, "R8", "be_oe on read", be_oe, 0);
            end else begin
                chk(iss_wdata == e_d, "R7", "iss_wdata", iss_wdata, e_d);
                if (e_lane == 2'b01) begin
                    chk(be_oe && be_n == 2'b10, "R10", "low byte be_n", be_n, 2);
                end else if (e_lane == 2'b10) begin
                    chk(be_oe && be_n == 2'b01, "R10", "high byte be_n", be_n, 1);
                end else begin
                    chk(be_oe && be_n == 2'b00, "R9", "full word be_n", be_n, 0);
                end
            end
        end else begin
            chk(be_oe == 1'b0, "R8", "be_oe when idle", be_oe, 0);
        end
    endtask

    task automatic cycle(bit v, bit w, int b, logic [1:0] lane, data_t d, output bit acc);
        int n;
        req_valid = v; req_write = w; req_bank = bank_t'(b);
        req_lane = lane; req_wdata = d;
        #1;
        if (v) begin
            n = need_f(b, w);
            chk(req_ready == (el >= n), tag_f(b, w), "req_ready", req_ready, el >= n);
        end
        acc = v && req_ready;
        e_v = acc; e_w = w; e_b = b; e_lane = lane; e_d = d;
        if (acc) begin
            hv = 1; hb = b; hw = w; el = 0;
        end else if (el < 31) begin
            el++;
        end
        @(negedge clk);
        check_iss();
    endtask

    task automatic send(bit w, int b, logic [1:0] lane, data_t d);
        bit acc;
        for (int k = 0; k < 64; k++) begin
            cycle(1'b1, w, b, lane, d, acc);
            if (acc) break;
        end
    endtask

    task automatic quiet(int n);
        bit acc;
        for (int k = 0; k < n; k++) cycle(1'b0, 1'b0, 0, 2'b00, '0, acc);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R6 watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_bank = '0;
        req_lane = 2'b00; req_wdata = '0;
        for (int i = 0; i < NBANK; i++) begin idle_a[i] = 15; turn_a[i] = 15; end
        apply_cfg();
        hv = 0; hb = 0; hw = 0; el = 31; e_v = 0;
        repeat (3) @(negedge clk);
        chk(iss_valid == 1'b0, "R11", "iss_valid in reset", iss_valid, 0);
        chk(be_oe == 1'b0, "R11", "be_oe in reset", be_oe, 0);
        chk(req_ready == 1'b1, "R11", "req_ready in reset", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);

        // directed: first access, then each history case with large counts
        send(1'b1, 0, 2'b00, 16'hA5A5);      // R5
        send(1'b1, 0, 2'b10, 16'h1200);      // R2 after 15 quiet cycles
        send(1'b0, 0, 2'b00, 16'h0000);      // R3 after 30
        send(1'b0, 1, 2'b00, 16'h0000);      // R4 uses bank 0 counts
        idle_a[1] = 2; turn_a[1] = 9; apply_cfg();
        send(1'b1, 1, 2'b01, 16'h0034);      // R3/R1 bank 1 counts: 11
        send(1'b1, 1, 2'b11, 16'hBEEF);      // R9 with lane 11, R2 gap 2
        quiet(40);
        send(1'b0, 2, 2'b00, 16'h0000);      // R6 long quiet: immediate

        // random traffic
        for (int r = 0; r < 360; r++) begin
            if (r % 90 == 0) begin
                for (int i = 0; i < NBANK; i++) begin
                    idle_a[i] = int'($urandom_range(0, 15));
                    turn_a[i] = int'($urandom_range(0, 15));
                end
                apply_cfg();
            end
            if ($urandom_range(0, 3) == 0) quiet(int'($urandom_range(1, 20)));
            send(1'($urandom_range(0, 1)), int'($urandom_range(0, NBANK-1)),
                 2'($urandom_range(0, 3)), data_t'($urandom));
        end
        quiet(2);

        done = 1;
        summary();
        $finish;
    end
endmodule